// File: doc/BRIEF.md
# Rotating XOR String Hash Unit

This unit turns a word of text into a short lookup address and checks that address against a small table of dictionary entries. Text arrives two characters at a time as one 16-bit value. Every step merges the character pair, together with a 16-bit constant chosen per instance, into the top 16 bits of a 22-bit hash register. The register is then rotated right by seven places. Because each unit has its own constant, a row of these units can hash the same word into different, independent locations.

A word begins with a clear strobe and ends with a finish strobe. The finish strobe freezes the hash and then does one of two things. In lookup mode it reads the valid bit at the hashed address and reports hit or miss on the next cycle. In load mode it sets that valid bit, which is how the dictionary is written into the table. A global wipe clears every valid bit. The 18-bit address output is bits 21..4 of the hash register. The table has 2^TBL_AW entries and is indexed by the low TBL_AW bits of that address.

The control is a four-state machine:
- IDLE accepts commands.
- MIX performs the hash step.
- RESULT presents the lookup answer.
- STORE is the cycle in which a dictionary write completes.

The transitions are:
- IDLE→MIX on an accepted pair.
- IDLE→RESULT on a lookup finish.
- IDLE→STORE on a load finish.
- IDLE→IDLE on a wipe, a word clear or no command.
- MIX→IDLE, RESULT→IDLE and STORE→IDLE unconditionally.

Top module: `str_hash_unit`

## Requirements
- R1: After reset, ready is 1, hit_valid is 0, hit is 0, addr is 0 and every table bit is 0.
- R2: In IDLE, word_clr sets the hash register to zero (addr reads 0 from the next cycle). It takes priority over pair_stb and word_end in the same cycle; the pair is not consumed and ready stays 1.
- R3: In IDLE with no wipe or clear, pair_stb captures pair_data, and ready is 0 for exactly the next cycle (MIX). At the end of that cycle the hash becomes rotr7(H XOR ((pair XOR hash_const) << 6)) over 22 bits, with pair bit 0 landing on hash bit 6.
- R4: The rotation is exactly seven places to the right: from a zero hash, pair 0xFFFF with hash_const 0x0000 yields hash 0x207FFF (addr 0x207FF).
- R5: addr always equals bits 21..4 of the hash register.
- R6: In IDLE with no other command, word_end with load_en=0 produces hit_valid=1 for exactly one cycle, the cycle after the strobe. In that cycle hit equals the table bit at index addr[TBL_AW-1:0].
- R7: In IDLE with no other command, word_end with load_en=1 sets the table bit at index addr[TBL_AW-1:0]. ready is 0 for exactly the next cycle and hit_valid stays 0.
- R8: tbl_clr in IDLE clears every table bit and takes priority over all other commands in that cycle.
- R9: While ready is 0, the inputs tbl_clr, word_clr, pair_stb and word_end are ignored.
- R10: The hash does not change except through MIX or a word clear. A lookup leaves addr unchanged, and repeating it gives the same answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_clr | input | 1 | Wipe all table valid bits |
| word_clr | input | 1 | Start a new word: zero the hash |
| pair_stb | input | 1 | Character pair present on pair_data |
| pair_data | input | 16 | Two characters, one step |
| hash_const | input | 16 | Per-instance hash constant |
| word_end | input | 1 | Finish the word: look up or load |
| load_en | input | 1 | With word_end: write instead of read |
| ready | output | 1 | Unit is in IDLE and accepts a command |
| addr | output | 18 | Hash bits 21..4 |
| hit_valid | output | 1 | One-cycle pulse marking a lookup answer |
| hit | output | 1 | Table bit read by the last lookup |

## Verification
The bench feeds a set of words, some loaded and some only looked up, and checks each one. A wrong rotation amount, a wrong merge offset or a missing constant would show up as an address mismatch. The fixed 0xFFFF case pins the exact bit motion of the rotate. Commands raised during the MIX cycle and combinations of simultaneous commands test the priority and the ignore rules: a unit that took a second pair, or cleared the hash mid-step, would hash the wrong word. Lookups repeated after a wipe and after a plain re-finish show whether the table and the frozen hash keep their state; a design that lost either would miss a stored word or report a stale hit.

// File: rtl/hsh_pkg.sv
package hsh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MIX    = 2'd1,
        ST_RESULT = 2'd2,
        ST_STORE  = 2'd3
    } hsh_state_e;

endpackage

// File: rtl/hsh_ctrl.sv
module hsh_ctrl
    import hsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tbl_clr,
    input  logic       word_clr,
    input  logic       pair_stb,
    input  logic       word_end,
    input  logic       load_en,
    output hsh_state_e state,
    output logic       do_wipe,
    output logic       do_hclr,
    output logic       do_cap,
    output logic       do_mix,
    output logic       do_rd,
    output logic       do_wr
);

    hsh_state_e state_nx;
    logic       idle;
    logic       fin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        idle    = (state == ST_IDLE);
        do_wipe = idle && tbl_clr;
        do_hclr = idle && !tbl_clr && word_clr;
        do_cap  = idle && !tbl_clr && !word_clr && pair_stb;
        fin     = idle && !tbl_clr && !word_clr && !pair_stb && word_end;
        do_rd   = fin && !load_en;
        do_wr   = fin && load_en;
        do_mix  = (state == ST_MIX);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (do_cap)     state_nx = ST_MIX;
                else if (do_rd) state_nx = ST_RESULT;
                else if (do_wr) state_nx = ST_STORE;
                else            state_nx = ST_IDLE;
            end
            ST_MIX:    state_nx = ST_IDLE;
            ST_RESULT: state_nx = ST_IDLE;
            ST_STORE:  state_nx = ST_IDLE;
        endcase
    end

    // R3: the hash step occupies a single cycle
    a_r3_mix_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MIX) |=> (state == ST_IDLE));

    // R9: nothing is accepted outside IDLE
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !(do_wipe || do_hclr || do_cap || do_rd || do_wr));

endmodule

// File: rtl/hsh_core.sv
module hsh_core #(
    parameter int HASH_W = 22,
    parameter int PAIR_W = 16,
    parameter int ROT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              mix,
    input  logic              hclr,
    input  logic [PAIR_W-1:0] pair_in,
    input  logic [PAIR_W-1:0] const_in,
    output logic [HASH_W-1:0] hash
);

    localparam int SHIFT = HASH_W - PAIR_W;

    logic [PAIR_W-1:0] pair_q;
    logic [HASH_W-1:0] merged;
    logic [HASH_W-1:0] rotated;

    always_comb begin
        merged  = hash ^ {pair_q ^ const_in, {SHIFT{1'b0}}};
        rotated = {merged[ROT-1:0], merged[HASH_W-1:ROT]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= '0;
            hash   <= '0;
        end else begin
            if (cap)       pair_q <= pair_in;
            if (hclr)      hash   <= '0;
            else if (mix)  hash   <= rotated;
        end
    end

    // R10: hash holds unless a step or a clear happens
    a_r10_hash_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!mix && !hclr) |=> $stable(hash));

    // R2: a word clear leaves a zero hash
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hclr |=> (hash == '0));

endmodule

// File: rtl/hsh_table.sv
module hsh_table #(
    parameter int TBL_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              rd,
    input  logic              wr,
    input  logic [TBL_AW-1:0] idx,
    output logic              hit
);

    localparam int DEPTH = 1 << TBL_AW;

    logic [DEPTH-1:0] vbits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbits <= '0;
            hit   <= 1'b0;
        end else begin
            if (wipe)    vbits      <= '0;
            else if (wr) vbits[idx] <= 1'b1;
            if (rd)      hit        <= vbits[idx];
        end
    end

    // R8: a wipe empties the whole table
    a_r8_wipe_all: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (vbits == '0));

    // R7: a load sets the addressed bit
    a_r7_store_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wipe) |=> vbits[$past(idx)]);

endmodule

// File: rtl/str_hash_unit.sv
module str_hash_unit
    import hsh_pkg::*;
#(
    parameter int HASH_W = 22,
    parameter int PAIR_W = 16,
    parameter int ROT    = 7,
    parameter int ADDR_W = 18,
    parameter int TBL_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_clr,
    input  logic              word_clr,
    input  logic              pair_stb,
    input  logic [PAIR_W-1:0] pair_data,
    input  logic [PAIR_W-1:0] hash_const,
    input  logic              word_end,
    input  logic              load_en,
    output logic              ready,
    output logic [ADDR_W-1:0] addr,
    output logic              hit_valid,
    output logic              hit
);

    localparam int ADDR_LSB = HASH_W - ADDR_W;

    hsh_state_e        state;
    logic              do_wipe, do_hclr, do_cap, do_mix, do_rd, do_wr;
    logic [HASH_W-1:0] hash;

    hsh_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tbl_clr  (tbl_clr),
        .word_clr (word_clr),
        .pair_stb (pair_stb),
        .word_end (word_end),
        .load_en  (load_en),
        .state    (state),
        .do_wipe  (do_wipe),
        .do_hclr  (do_hclr),
        .do_cap   (do_cap),
        .do_mix   (do_mix),
        .do_rd    (do_rd),
        .do_wr    (do_wr)
    );

    hsh_core #(
        .HASH_W (HASH_W),
        .PAIR_W (PAIR_W),
        .ROT    (ROT)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (do_cap),
        .mix      (do_mix),
        .hclr     (do_hclr),
        .pair_in  (pair_data),
        .const_in (hash_const),
        .hash     (hash)
    );

    hsh_table #(
        .TBL_AW (TBL_AW)
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (do_wipe),
        .rd    (do_rd),
        .wr    (do_wr),
        .idx   (addr[TBL_AW-1:0]),
        .hit   (hit)
    );

    always_comb begin
        ready     = (state == ST_IDLE);
        hit_valid = (state == ST_RESULT);
        addr      = hash[HASH_W-1:ADDR_LSB];
    end

    // R6: the answer is a single-cycle pulse
    a_r6_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> !hit_valid);

    // R6: a plain lookup strobe is answered on the next cycle
    a_r6_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && word_end && !load_en && !tbl_clr && !word_clr && !pair_stb)
        |=> (hit_valid && !ready));

    // R7: a load finish gives no answer pulse
    a_r7_load_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && word_end && load_en && !tbl_clr && !word_clr && !pair_stb)
        |=> (!hit_valid && !ready));

    // R3: an accepted pair makes the unit busy for one cycle
    a_r3_busy_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pair_stb && !tbl_clr && !word_clr) |=> (!ready && !hit_valid));

    // R10: a lookup does not move the address
    a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $stable(addr));

endmodule

// File: tb/str_hash_unit_bench.sv
`timescale 1ns/1ps
module str_hash_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_clr = 1'b0, word_clr = 1'b0, pair_stb = 1'b0;
    logic        word_end = 1'b0, load_en = 1'b0;
    logic [15:0] pair_data = '0, hash_const = '0;
    logic        ready, hit_valid, hit;
    logic [17:0] addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [21:0] mh;
    bit          mtab [256];

    always #5 clk = ~clk;

    str_hash_unit u_str_hash_unit (
        .clk(clk), .rst_n(rst_n), .tbl_clr(tbl_clr), .word_clr(word_clr),
        .pair_stb(pair_stb), .pair_data(pair_data), .hash_const(hash_const),
        .word_end(word_end), .load_en(load_en), .ready(ready), .addr(addr),
        .hit_valid(hit_valid), .hit(hit)
    );

    localparam int NV = 8;
    localparam logic [15:0] V_K  [NV] = '{16'hC8A3, 16'hC8A3, 16'h1F35, 16'hC8A3,
                                          16'hC8A3, 16'h1F35, 16'hC8A3, 16'h0000};
    localparam int          V_N  [NV] = '{2, 2, 3, 1, 2, 2, 3, 1};
    localparam logic [15:0] V_P0 [NV] = '{16'h7468, 16'h646F, 16'h6269, 16'h615F,
                                          16'h6361, 16'h7468, 16'h6669, 16'hFFFF};
    localparam logic [15:0] V_P1 [NV] = '{16'h655F, 16'h675F, 16'h7264, 16'h0000,
                                          16'h745F, 16'h655F, 16'h7368, 16'h0000};
    localparam logic [15:0] V_P2 [NV] = '{16'h0000, 16'h0000, 16'h735F, 16'h0000,
                                          16'h0000, 16'h0000, 16'h5F5F, 16'h0000};
    localparam bit          V_LD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

    function automatic logic [21:0] step(logic [21:0] h, logic [15:0] p, logic [15:0] k);
        logic [21:0] m;
        m = h ^ {p ^ k, 6'b000000};
        return {m[6:0], m[21:7]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic new_word();
        word_clr = 1'b1;
        @(negedge clk);
        word_clr = 1'b0;
        mh = '0;
        check("R2 clear", {14'd0, addr}, 32'd0);
    endtask

    task automatic feed(logic [15:0] p, logic [15:0] k);
        pair_stb = 1'b1; pair_data = p; hash_const = k;
        @(negedge clk);
        pair_stb = 1'b0;
        check("R3 busy in step", {31'd0, ready}, 32'd0);
        @(negedge clk);
        check("R3 ready after step", {31'd0, ready}, 32'd1);
        mh = step(mh, p, k);
        check("R3/R5 addr", {14'd0, addr}, {14'd0, mh[21:4]});
    endtask

    task automatic finish(bit ld);
        logic [17:0] a0;
        a0 = addr;
        load_en = ld; word_end = 1'b1;
        @(negedge clk);
        word_end = 1'b0; load_en = 1'b0;
        if (ld) begin
            check("R7 no pulse", {31'd0, hit_valid}, 32'd0);
            check("R7 busy", {31'd0, ready}, 32'd0);
            mtab[a0[7:0]] = 1'b1;
        end else begin
            check("R6 pulse", {31'd0, hit_valid}, 32'd1);
            check("R6 hit", {31'd0, hit}, {31'd0, mtab[a0[7:0]]});
        end
        check("R10 addr held", {14'd0, addr}, {14'd0, a0});
        @(negedge clk);
        check("R6 pulse ends", {31'd0, hit_valid}, 32'd0);
        check("R6 ready again", {31'd0, ready}, 32'd1);
    endtask

    task automatic run_vec(int i, bit ld);
        new_word();
        feed(V_P0[i], V_K[i]);
        if (V_N[i] > 1) feed(V_P1[i], V_K[i]);
        if (V_N[i] > 2) feed(V_P2[i], V_K[i]);
        finish(ld);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (mtab[i]) mtab[i] = 1'b0;
        mh = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'd0, ready}, 32'd1);
        check("R1 hit_valid", {31'd0, hit_valid}, 32'd0);
        check("R1 hit", {31'd0, hit}, 32'd0);
        check("R1 addr", {14'd0, addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty table after reset
        run_vec(0, 1'b0);

        // dictionary load
        for (int i = 0; i < NV; i++) if (V_LD[i]) run_vec(i, 1'b1);
        // lookup pass over all words
        for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

        // R4 exact rotation
        new_word();
        feed(16'hFFFF, 16'h0000);
        check("R4 rotate", {14'd0, addr}, 32'h207FF);

        // R10 repeat lookup without clear
        finish(1'b0);
        finish(1'b0);

        // R2 word clear beats pair in the same cycle
        new_word();
        feed(16'h7468, 16'hC8A3);
        word_clr = 1'b1; pair_stb = 1'b1; pair_data = 16'h1234; word_end = 1'b1;
        @(negedge clk);
        word_clr = 1'b0; pair_stb = 1'b0; word_end = 1'b0;
        check("R2 priority ready", {31'd0, ready}, 32'd1);
        check("R2 priority no pulse", {31'd0, hit_valid}, 32'd0);
        check("R2 priority addr", {14'd0, addr}, 32'd0);
        mh = '0;

        // R9 commands during the step are ignored
        pair_stb = 1'b1; pair_data = 16'h7468; hash_const = 16'hC8A3;
        @(negedge clk);
        pair_data = 16'h1234; word_clr = 1'b1; tbl_clr = 1'b1; word_end = 1'b1;
        @(negedge clk);
        pair_stb = 1'b0; word_clr = 1'b0; tbl_clr = 1'b0; word_end = 1'b0;
        mh = step(mh, 16'h7468, 16'hC8A3);
        check("R9 no pulse", {31'd0, hit_valid}, 32'd0);
        check("R9 addr", {14'd0, addr}, {14'd0, mh[21:4]});
        feed(16'h655F, 16'hC8A3);
        finish(1'b0);
        check("R9 table kept", {31'd0, hit}, 32'd1);

        // R8 wipe beats a lookup, then everything misses
        tbl_clr = 1'b1; word_end = 1'b1;
        @(negedge clk);
        tbl_clr = 1'b0; word_end = 1'b0;
        check("R8 no pulse", {31'd0, hit_valid}, 32'd0);
        check("R8 ready", {31'd0, ready}, 32'd1);
        foreach (mtab[i]) mtab[i] = 1'b0;
        run_vec(0, 1'b0);
        check("R8 miss after wipe", {31'd0, hit}, 32'd0);
        run_vec(2, 1'b0);
        check("R8 miss after wipe 2", {31'd0, hit}, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule